// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the interrupt control register of a small microcontroller core. It is one 8-bit register that software reads and writes over a simple register bus. It holds a global enable, an enable for the peripheral group, and three enable/flag pairs. The three flagged sources are a timer rollover pulse, a rising edge on the synchronized external interrupt pin, and a change on any of the port pins selected by a per-pin mask. The block drives one combined interrupt request to the core.

A flag records its event whatever the enables say, and it stays set until software writes it to 0. The port-change source compares each selected pin with a snapshot of the pins. The snapshot is taken at reset and again on every bus read of the port address. A mismatch therefore stays visible until software reads the port. The register decodes at two mirrored addresses. Read data and the interrupt request both come from registers, so each appears one clock after the state it reflects.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous reset all eight register bits read 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: A write at address 0x0B loads all eight bits. The bit layout from bit 7 down to bit 0 is: global enable, peripheral enable, timer enable, pin enable, port-change enable, timer flag, pin flag, port-change flag. The register value appears on `bus_rdata_o` one clock after a read strobe at 0x0B. A read at any address that is not decoded returns 0.
- R3: Address 0x8B reaches the same register for both reads and writes. Writes to any other address leave the register unchanged.
- R4: A one-cycle `tmr_ovf_i` pulse sets the timer flag (bit 2), even when every enable bit is 0.
- R5: A 0-to-1 transition of `ext_pin_i` sets the pin flag (bit 1). A pin held high, or a falling pin, does not set it.
- R6: The port-change flag (bit 0) is set while at least one pin with its `chg_mask_i` bit at 1 differs from the snapshot. Pins whose mask bit is 0 have no effect.
- R7: The snapshot is loaded from `port_pins_i` during reset and on each bus read at the port address 0x05. While a mismatch remains, a cleared port-change flag sets again.
- R8: Once set, a flag holds its value until a bus write puts 0 in that bit.
- R9: If an event and a bus write of 0 to its flag fall in the same cycle, the flag ends up at 1.
- R10: `irq_o` equals global enable AND ((timer enable AND timer flag) OR (pin enable AND pin flag) OR (port-change enable AND port-change flag) OR (peripheral enable AND `periph_req_i`)). It follows the register state with one clock of delay.
- R11: When the global enable is 0, `irq_o` stays 0. When the peripheral enable is 0, `periph_req_i` alone cannot raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf_i | input | 1 | One-cycle timer rollover pulse |
| ext_pin_i | input | 1 | Synchronized external interrupt pin |
| port_pins_i | input | PORT_W | Port pin levels |
| chg_mask_i | input | PORT_W | Per-pin change-detect mask |
| periph_req_i | input | 1 | Combined peripheral interrupt request |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
The hardest cases to reach are the ones where a single clock edge carries two actions. One is a flag clear that lands on the same edge as a new event. The other is a port-change mismatch that outlives a software clear. For the first, the bench drives a write of 0 and the timer pulse in the same cycle. For the second, it changes a selected pin and clears the flag without reading the port, and the flag must come back. Only after a read at the port address may a clear stick.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W       = 8;
  localparam int NUM_FLAGS   = 3;
  localparam int BIT_GLB_EN  = 7;
  localparam int BIT_PER_EN  = 6;
  localparam int BIT_TMR_EN  = 5;
  localparam int BIT_PIN_EN  = 4;
  localparam int BIT_CHG_EN  = 3;
  localparam int BIT_TMR_FLG = 2;
  localparam int BIT_PIN_FLG = 1;
  localparam int BIT_CHG_FLG = 0;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  // prev_q is loaded during reset so that a pin already high gives no edge
  always_ff @(posedge clk) begin
    prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q & ~rst;
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] mask_i,
  input  logic         resync_i,
  output logic         chg_o
);
  logic [N-1:0] snap_q;
  logic [N-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst || resync_i) snap_q <= pins_i;
  end

  assign diff  = (pins_i ^ snap_q) & mask_i;
  assign chg_o = |diff;

  // R7
  snap_load_chk: assert property (@(posedge clk) resync_i |=> (snap_q == $past(pins_i)));
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_FLAGS-1:0] evt_i,
  output logic [REG_W-1:0]     ctl_o
);
  logic [REG_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)       ctl_q[REG_W-1:NUM_FLAGS] <= '0;
    else if (wr_i) ctl_q[REG_W-1:NUM_FLAGS] <= wdata_i[REG_W-1:NUM_FLAGS];
  end

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           ctl_q[k] <= 1'b0;
      else if (evt_i[k]) ctl_q[k] <= 1'b1;
      else if (wr_i)     ctl_q[k] <= wdata_i[k];
    end

    // R4 R5 R6 R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst) evt_i[k] |=> ctl_q[k]);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst) (ctl_q[k] && !wr_i) |=> ctl_q[k]);
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (ctl_q == '0));

  assign ctl_o = ctl_q;
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int              PORT_W    = 6,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_MAIN = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_ALT  = 8'h8B,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_ovf_i,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_pins_i,
  input  logic [PORT_W-1:0] chg_mask_i,
  input  logic              periph_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  logic                 hit;
  logic                 pin_rise;
  logic                 port_chg;
  logic [NUM_FLAGS-1:0] evt;
  logic [REG_W-1:0]     ctl;
  logic                 req_any;

  assign hit = (bus_addr_i == ADDR_MAIN) || (bus_addr_i == ADDR_ALT);

  irq_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (ext_pin_i),
    .rise_o (pin_rise)
  );

  irq_chg_det #(.N(PORT_W)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .pins_i   (port_pins_i),
    .mask_i   (chg_mask_i),
    .resync_i (bus_rd_i && (bus_addr_i == ADDR_PORT)),
    .chg_o    (port_chg)
  );

  always_comb begin
    evt = '0;
    evt[BIT_TMR_FLG] = tmr_ovf_i;
    evt[BIT_PIN_FLG] = pin_rise;
    evt[BIT_CHG_FLG] = port_chg;
  end

  irq_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr_i && hit),
    .wdata_i (bus_wdata_i),
    .evt_i   (evt),
    .ctl_o   (ctl)
  );

  assign req_any = (ctl[BIT_TMR_EN] & ctl[BIT_TMR_FLG])
                 | (ctl[BIT_PIN_EN] & ctl[BIT_PIN_FLG])
                 | (ctl[BIT_CHG_EN] & ctl[BIT_CHG_FLG])
                 | (ctl[BIT_PER_EN] & periph_req_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      irq_o       <= ctl[BIT_GLB_EN] & req_any;
      bus_rdata_o <= (bus_rd_i && hit) ? ctl : '0;
    end
  end

  // R11
  glb_block_chk: assert property (@(posedge clk) disable iff (rst) !ctl[BIT_GLB_EN] |=> !irq_o);
  // R11
  per_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl[BIT_PER_EN] && ((ctl[5:3] & ctl[2:0]) == 3'b000)) |=> !irq_o);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst) !(bus_rd_i && hit) |=> (bus_rdata_o == 8'h00));
  // R3
  wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr_i && hit) && (evt == '0)) |=> $stable(ctl));
endmodule

// File: tb/sim_irq_ctl_top.sv
module sim_irq_ctl_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       tmr_ovf, ext_pin, periph_req, bus_wr, bus_rd;
  logic [5:0] pins, mask;
  logic [7:0] addr, wdata, rdata, v;
  logic       irq;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  irq_ctl_top u0 (
    .clk(clk), .rst(rst), .tmr_ovf_i(tmr_ovf), .ext_pin_i(ext_pin),
    .port_pins_i(pins), .chg_mask_i(mask), .periph_req_i(periph_req),
    .bus_addr_i(addr), .bus_wr_i(bus_wr), .bus_wdata_i(wdata),
    .bus_rd_i(bus_rd), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = rdata;
  endtask

  task automatic tpulse();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rd(8'h0B, v); chk("R1 reg", v, 8'h00);
  endtask

  task automatic t_rw();
    wr(8'h0B, 8'hE0); rd(8'h0B, v); chk("R2 rw", v, 8'hE0);
    rd(8'h8B, v); chk("R3 mirror read", v, 8'hE0);
    wr(8'h8B, 8'h18); rd(8'h0B, v); chk("R3 mirror write", v, 8'h18);
    wr(8'h0C, 8'hFF); rd(8'h0B, v); chk("R3 other addr", v, 8'h18);
    rd(8'h0C, v); chk("R2 undecoded read", v, 8'h00);
    wr(8'h0B, 8'h00);
  endtask

  task automatic t_tmr();
    tpulse(); cyc(5); rd(8'h0B, v); chk("R4 R8 tmr flag", v, 8'h04);
    chk("R11 no irq", {7'd0, irq}, 8'h00);
    wr(8'h0B, 8'h00); rd(8'h0B, v); chk("R8 clear", v, 8'h00);
  endtask

  task automatic t_ext();
    @(negedge clk); ext_pin = 1'b1; cyc(2);
    rd(8'h0B, v); chk("R5 rise", v, 8'h02);
    wr(8'h0B, 8'h00); cyc(3);
    rd(8'h0B, v); chk("R5 level", v, 8'h00);
    @(negedge clk); ext_pin = 1'b0; cyc(2);
    rd(8'h0B, v); chk("R5 fall", v, 8'h00);
  endtask

  task automatic t_port();
    @(negedge clk); mask = 6'h01; pins = 6'h02; cyc(2);
    rd(8'h0B, v); chk("R6 masked pin", v, 8'h00);
    rd(8'h05, v);
    @(negedge clk); pins = 6'h03; cyc(2);
    rd(8'h0B, v); chk("R6 enabled pin", v, 8'h01);
    wr(8'h0B, 8'h00); rd(8'h0B, v); chk("R7 mismatch persists", v, 8'h01);
    rd(8'h05, v); wr(8'h0B, 8'h00);
    rd(8'h0B, v); chk("R7 resync then clear", v, 8'h00);
  endtask

  task automatic t_race();
    @(negedge clk); addr = 8'h0B; wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd(8'h0B, v); chk("R9 set wins", v, 8'h04);
    wr(8'h0B, 8'h00);
  endtask

  task automatic t_irq();
    wr(8'h0B, 8'hA0); tpulse(); cyc(1);
    chk("R10 timer irq", {7'd0, irq}, 8'h01);
    wr(8'h0B, 8'h24); cyc(1);
    chk("R11 global off", {7'd0, irq}, 8'h00);
    wr(8'h0B, 8'h84); cyc(1);
    chk("R10 source disabled", {7'd0, irq}, 8'h00);
    wr(8'h0B, 8'hC0); @(negedge clk); periph_req = 1'b1; cyc(2);
    chk("R10 periph irq", {7'd0, irq}, 8'h01);
    wr(8'h0B, 8'h80); cyc(1);
    chk("R11 periph off", {7'd0, irq}, 8'h00);
    @(negedge clk); periph_req = 1'b0;
    wr(8'h0B, 8'h00);
  endtask

  initial begin
    rst = 1'b1; tmr_ovf = 0; ext_pin = 0; periph_req = 0; bus_wr = 0; bus_rd = 0;
    pins = 6'h00; mask = 6'h00; addr = 8'h00; wdata = 8'h00;
    cyc(3); rst = 1'b0; cyc(1);
    t_reset(); t_rw(); t_tmr(); t_ext(); t_port(); t_race(); t_irq();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule